// File: doc/BRIEF.md
# Byte-Lane Bus State Trigger

This block watches the bus states captured from a 16-bit processor and raises a trigger when a state matches a programmed pattern. A captured state has a 24-bit address, 16 bits of data and a transfer-size code: full word, lower byte or upper byte. The address is compared under a per-bit don't-care mask. The data is compared as two separate 8-bit lanes, and each lane has its own value and its own don't-care mask. The transfer size decides which lanes take part in the compare.

A processor can move a byte on either half of the data bus, and the lane it will use is often not known in advance. To catch such a byte on either half, program the same value into both lanes and set the size qualifier to byte transfers. The lane named by the transfer's size code is then the only one checked.

The trigger is registered and latched. It rises in the cycle after the matching state is strobed in and stays high until software writes the clear register. A small write-only register port sets the pattern.

Top module: `bus_trig`

## Requirements
- R1: After reset the trigger output is low. The qualifier resets to off (code 3) and all masks reset to don't-care, so no strobed state can set the trigger until the qualifier is programmed.
- R2: The address matches when every address bit whose mask bit is 0 equals the pattern bit. A mask bit of 1 makes that address bit don't-care. Register 0 holds the address value in bits [23:0] and register 1 holds the address mask in bits [23:0].
- R3: For a word transfer (size code 0), both data lanes must match: the lower lane on data[7:0] and the upper lane on data[15:8].
- R4: For a lower-byte transfer (size code 1), only the lower lane is evaluated and data[15:8] has no effect.
- R5: For an upper-byte transfer (size code 2), only the upper lane is evaluated and data[7:0] has no effect.
- R6: The qualifier in register 3 bits [1:0] selects which transfers may match: 0 any size, 1 word only, 2 byte only (either lane), 3 off. Size code 3 never matches.
- R7: A state is compared only in a cycle where the sample-valid strobe is high. With the strobe low, matching inputs have no effect.
- R8: The trigger rises on the clock edge that samples a matching strobed state, so it is seen high in the following cycle and not before. Once high it stays high through later non-matching states.
- R9: Any write to register 4 clears the trigger at that edge. If a matching state is strobed in the same cycle as the clear, the trigger stays high.
- R10: Register 2 holds the lane patterns: lower value in [7:0], upper value in [15:8], lower mask in [23:16] and upper mask in [31:24]. With the same value in both lanes and the byte qualifier, a byte carrying that value triggers on either half of the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write enable |
| cfg_addr | input | 3 | Register index |
| cfg_wdata | input | 32 | Register write data |
| smp_vld | input | 1 | Captured bus state is valid this cycle |
| smp_addr | input | 24 | Captured address |
| smp_data | input | 16 | Captured data, two byte lanes |
| smp_xfer | input | 2 | Transfer size: 0 word, 1 lower byte, 2 upper byte |
| trig_o | output | 1 | Latched trigger |

## Verification
A wrong lane select or a wrong mask polarity shows up as a trigger that is missing or unexpected in the cycle right after a single strobed state. Each directed scenario therefore strobes one state and checks the trigger one cycle later. A trigger latch that leaks or drops would show as the output changing during later non-matching or idle cycles, so those cycles are watched as well. A clear that loses to a match, or that fails to take effect, becomes visible in the cycle after the register write.

// File: rtl/bus_trig_pkg.sv
package bus_trig_pkg;
  typedef enum logic [1:0] {
    XFER_WORD = 2'd0,
    XFER_LO   = 2'd1,
    XFER_HI   = 2'd2,
    XFER_BAD  = 2'd3
  } xfer_e;

  typedef enum logic [1:0] {
    QUAL_ANY  = 2'd0,
    QUAL_WORD = 2'd1,
    QUAL_BYTE = 2'd2,
    QUAL_OFF  = 2'd3
  } qual_e;

  localparam logic [2:0] REG_ADDR_VAL = 3'd0;
  localparam logic [2:0] REG_ADDR_DC  = 3'd1;
  localparam logic [2:0] REG_LANES    = 3'd2;
  localparam logic [2:0] REG_QUAL     = 3'd3;
  localparam logic [2:0] REG_CLEAR    = 3'd4;

  // transfer size permitted by the qualifier
  function automatic logic size_allowed(qual_e q, xfer_e s);
    case (q)
      QUAL_ANY:  return s != XFER_BAD;
      QUAL_WORD: return s == XFER_WORD;
      QUAL_BYTE: return (s == XFER_LO) || (s == XFER_HI);
      default:   return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/bus_trig_regs.sv
module bus_trig_regs
  import bus_trig_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int LANE_W = 8,
  parameter int CFG_W  = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cfg_we,
  input  logic [2:0]                 cfg_addr,
  input  logic [CFG_W-1:0]           cfg_wdata,
  output logic [ADDR_W-1:0]          addr_val,
  output logic [ADDR_W-1:0]          addr_dc,
  output logic [1:0][LANE_W-1:0]     lane_val,
  output logic [1:0][LANE_W-1:0]     lane_dc,
  output qual_e                      qual,
  output logic                       clr_pulse
);
  localparam int LANES_W = 4 * LANE_W;

  logic [CFG_W-1:0] lanes_raw;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_val  <= '0;
      addr_dc   <= '1;
      lanes_raw <= {{(2*LANE_W){1'b1}}, {(CFG_W-2*LANE_W){1'b0}}};
      qual      <= QUAL_OFF;
    end else if (cfg_we) begin
      case (cfg_addr)
        REG_ADDR_VAL: addr_val  <= cfg_wdata[ADDR_W-1:0];
        REG_ADDR_DC:  addr_dc   <= cfg_wdata[ADDR_W-1:0];
        REG_LANES:    lanes_raw <= cfg_wdata;
        REG_QUAL:     qual      <= qual_e'(cfg_wdata[1:0]);
        default: ;
      endcase
    end
  end

  assign lane_val[0] = lanes_raw[LANE_W-1:0];
  assign lane_val[1] = lanes_raw[2*LANE_W-1:LANE_W];
  assign lane_dc[0]  = lanes_raw[3*LANE_W-1:2*LANE_W];
  assign lane_dc[1]  = lanes_raw[LANES_W-1:3*LANE_W];
  assign clr_pulse   = cfg_we && (cfg_addr == REG_CLEAR);
endmodule

// File: rtl/bus_trig_match.sv
module bus_trig_match
  import bus_trig_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int LANE_W = 8
) (
  input  logic [ADDR_W-1:0]      smp_addr,
  input  logic [1:0][LANE_W-1:0] smp_data,
  input  xfer_e                  xfer,
  input  logic [ADDR_W-1:0]      addr_val,
  input  logic [ADDR_W-1:0]      addr_dc,
  input  logic [1:0][LANE_W-1:0] lane_val,
  input  logic [1:0][LANE_W-1:0] lane_dc,
  input  qual_e                  qual,
  output logic                   addr_hit,
  output logic [1:0]             lane_hit,
  output logic                   size_ok,
  output logic                   hit
);
  function automatic logic addr_eq(logic [ADDR_W-1:0] a, logic [ADDR_W-1:0] p,
                                   logic [ADDR_W-1:0] dc);
    return ((a ^ p) & ~dc) == '0;
  endfunction

  function automatic logic lane_eq(logic [LANE_W-1:0] a, logic [LANE_W-1:0] p,
                                   logic [LANE_W-1:0] dc);
    return ((a ^ p) & ~dc) == '0;
  endfunction

  assign addr_hit = addr_eq(smp_addr, addr_val, addr_dc);

  for (genvar g = 0; g < 2; g++) begin : g_lane
    assign lane_hit[g] = lane_eq(smp_data[g], lane_val[g], lane_dc[g]);
  end

  logic data_ok;
  always_comb begin
    case (xfer)
      XFER_WORD: data_ok = &lane_hit;
      XFER_LO:   data_ok = lane_hit[0];
      XFER_HI:   data_ok = lane_hit[1];
      default:   data_ok = 1'b0;
    endcase
  end

  assign size_ok = size_allowed(qual, xfer);
  assign hit     = addr_hit && data_ok && size_ok;
endmodule

// File: rtl/bus_trig.sv
module bus_trig
  import bus_trig_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int LANE_W = 8,
  parameter int CFG_W  = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [2:0]          cfg_addr,
  input  logic [CFG_W-1:0]    cfg_wdata,
  input  logic                smp_vld,
  input  logic [ADDR_W-1:0]   smp_addr,
  input  logic [2*LANE_W-1:0] smp_data,
  input  logic [1:0]          smp_xfer,
  output logic                trig_o
);
  logic [ADDR_W-1:0]      addr_val, addr_dc;
  logic [1:0][LANE_W-1:0] lane_val, lane_dc;
  qual_e                  qual;
  logic                   clr_pulse;
  logic                   addr_hit, size_ok, hit;
  logic [1:0]             lane_hit;
  logic                   strobe_hit;
  logic                   trig_q;

  bus_trig_regs #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .CFG_W(CFG_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .addr_val(addr_val), .addr_dc(addr_dc),
    .lane_val(lane_val), .lane_dc(lane_dc), .qual(qual), .clr_pulse(clr_pulse)
  );

  bus_trig_match #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_match (
    .smp_addr(smp_addr), .smp_data(smp_data), .xfer(xfer_e'(smp_xfer)),
    .addr_val(addr_val), .addr_dc(addr_dc), .lane_val(lane_val),
    .lane_dc(lane_dc), .qual(qual), .addr_hit(addr_hit),
    .lane_hit(lane_hit), .size_ok(size_ok), .hit(hit)
  );

  assign strobe_hit = smp_vld && hit;

  // a match in the clearing cycle wins
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          trig_q <= 1'b0;
    else if (strobe_hit) trig_q <= 1'b1;
    else if (clr_pulse)  trig_q <= 1'b0;
  end

  assign trig_o = trig_q;
endmodule

// File: rtl/bus_trig_chk.sv
module bus_trig_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       smp_vld,
  input logic [1:0] xfer,
  input logic       hit,
  input logic [1:0] lane_hit,
  input logic       clr,
  input logic       trig
);
  a_r8_rise_needs_match: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trig) |-> $past(smp_vld && hit));
  a_r8_latched: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && !clr) |=> trig);
  a_r7_strobe_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (!trig && !smp_vld) |=> !trig);
  a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !(smp_vld && hit)) |=> !trig);
  a_r9_match_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_vld && hit) |=> trig);
  a_r3_word_both: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer == 2'd0 && hit) |-> (lane_hit == 2'b11));
  a_r4_lower_lane: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer == 2'd1 && hit) |-> lane_hit[0]);
  a_r5_upper_lane: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer == 2'd2 && hit) |-> lane_hit[1]);
  a_r6_bad_size: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer == 2'd3) |-> !hit);
endmodule

bind bus_trig bus_trig_chk u_chk (
  .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .xfer(smp_xfer),
  .hit(hit), .lane_hit(lane_hit), .clr(clr_pulse), .trig(trig_o)
);

// File: tb/tb_bus_trig.sv
module tb_bus_trig;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        smp_vld = 1'b0;
  logic [23:0] smp_addr = '0;
  logic [15:0] smp_data = '0;
  logic [1:0]  smp_xfer = '0;
  logic        trig_o;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  bus_trig dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .smp_vld(smp_vld), .smp_addr(smp_addr),
    .smp_data(smp_data), .smp_xfer(smp_xfer), .trig_o(trig_o)
  );

  task automatic check(input string req, input logic exp);
    n_chk++;
    if (trig_o !== exp) begin
      n_fail++;
      $display("FAIL %s trig_o=%b expected=%b at %0t", req, trig_o, exp, $time);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // one state strobed for one edge; returns at the negedge after it
  task automatic smp(input logic [23:0] a, input logic [15:0] d,
                     input logic [1:0] x, input logic v);
    @(negedge clk);
    smp_vld = v; smp_addr = a; smp_data = d; smp_xfer = x;
    @(negedge clk);
    smp_vld = 1'b0;
  endtask

  task automatic clear();
    wr(3'd4, 32'd0);
  endtask

  // qual, address value, address mask, lanes
  task automatic setup(input logic [1:0] q, input logic [23:0] av,
                       input logic [23:0] am, input logic [31:0] ln);
    wr(3'd0, {8'd0, av});
    wr(3'd1, {8'd0, am});
    wr(3'd2, ln);
    wr(3'd3, {30'd0, q});
    clear();
  endtask

  task automatic t_reset();
    check("R1 reset", 1'b0);
    smp(24'h0, 16'h0, 2'd0, 1'b1);
    check("R1 qualifier off after reset", 1'b0);
  endtask

  task automatic t_addr();
    setup(2'd0, 24'h123456, 24'h0, 32'hFFFF_0000);
    smp(24'h123457, 16'h0, 2'd0, 1'b1);
    check("R2 address mismatch", 1'b0);
    smp(24'h123456, 16'h0, 2'd0, 1'b1);
    check("R2 address match", 1'b1);
    setup(2'd0, 24'h123456, 24'h00000F, 32'hFFFF_0000);
    smp(24'h12345A, 16'h0, 2'd0, 1'b1);
    check("R2 masked low nibble", 1'b1);
    clear();
    smp(24'h12355A, 16'h0, 2'd0, 1'b1);
    check("R2 unmasked bit differs", 1'b0);
  endtask

  task automatic t_word();
    setup(2'd0, 24'h0, 24'hFFFFFF, 32'h0000_1234);
    smp(24'h0, 16'h1234, 2'd0, 1'b1);
    check("R3 word both lanes", 1'b1);
    clear();
    smp(24'h0, 16'h1235, 2'd0, 1'b1);
    check("R3 word lower lane differs", 1'b0);
    smp(24'h0, 16'h1334, 2'd0, 1'b1);
    check("R3 word upper lane differs", 1'b0);
  endtask

  task automatic t_bytes();
    setup(2'd0, 24'h0, 24'hFFFFFF, 32'h0000_1234);
    smp(24'h0, 16'hFF34, 2'd1, 1'b1);
    check("R4 lower byte, upper ignored", 1'b1);
    clear();
    smp(24'h0, 16'h1235, 2'd1, 1'b1);
    check("R4 lower byte differs", 1'b0);
    smp(24'h0, 16'h12AB, 2'd2, 1'b1);
    check("R5 upper byte, lower ignored", 1'b1);
    clear();
    smp(24'h0, 16'h1334, 2'd2, 1'b1);
    check("R5 upper byte differs", 1'b0);
  endtask

  task automatic t_qual();
    setup(2'd1, 24'h0, 24'hFFFFFF, 32'h0000_1234);
    smp(24'h0, 16'h1234, 2'd1, 1'b1);
    check("R6 word-only rejects byte", 1'b0);
    smp(24'h0, 16'h1234, 2'd0, 1'b1);
    check("R6 word-only takes word", 1'b1);
    setup(2'd2, 24'h0, 24'hFFFFFF, 32'h0000_1234);
    smp(24'h0, 16'h1234, 2'd0, 1'b1);
    check("R6 byte-only rejects word", 1'b0);
    setup(2'd3, 24'h0, 24'hFFFFFF, 32'hFFFF_0000);
    smp(24'h0, 16'h0, 2'd0, 1'b1);
    check("R6 qualifier off", 1'b0);
    setup(2'd0, 24'h0, 24'hFFFFFF, 32'hFFFF_0000);
    smp(24'h0, 16'h0, 2'd3, 1'b1);
    check("R6 size code 3 never matches", 1'b0);
  endtask

  task automatic t_vld();
    setup(2'd0, 24'h0, 24'hFFFFFF, 32'hFFFF_0000);
    smp(24'h0, 16'h0, 2'd0, 1'b0);
    check("R7 strobe low ignored", 1'b0);
  endtask

  task automatic t_latch();
    setup(2'd0, 24'hABCDEF, 24'h0, 32'hFFFF_0000);
    @(negedge clk);
    smp_vld = 1'b1; smp_addr = 24'hABCDEF; smp_data = 16'h0; smp_xfer = 2'd0;
    #1;
    check("R8 not high before edge", 1'b0);
    @(negedge clk);
    smp_vld = 1'b0;
    check("R8 high the cycle after", 1'b1);
    smp(24'h000000, 16'h0, 2'd0, 1'b1);
    repeat (3) @(negedge clk);
    check("R8 stays latched", 1'b1);
  endtask

  task automatic t_clear();
    clear();
    check("R9 clear drops trigger", 1'b0);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 3'd4; cfg_wdata = '0;
    smp_vld = 1'b1; smp_addr = 24'hABCDEF; smp_data = 16'h0; smp_xfer = 2'd0;
    @(negedge clk);
    cfg_we = 1'b0; smp_vld = 1'b0;
    check("R9 match wins over clear", 1'b1);
    clear();
  endtask

  task automatic t_lane_any();
    setup(2'd2, 24'h0, 24'hFFFFFF, 32'h0000_5A5A);
    smp(24'h0, 16'h005A, 2'd1, 1'b1);
    check("R10 byte on lower half", 1'b1);
    clear();
    smp(24'h0, 16'h5A00, 2'd2, 1'b1);
    check("R10 byte on upper half", 1'b1);
    clear();
    smp(24'h0, 16'h5A00, 2'd1, 1'b1);
    check("R10 wrong lane data", 1'b0);
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired trig_o=%b expected=done", trig_o);
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_addr();
    t_word();
    t_bytes();
    t_qual();
    t_vld();
    t_latch();
    t_clear();
    t_lane_any();
    finish_up();
  end
endmodule